// File: doc/BRIEF.md
# Level-Sensed DMA Request Front End

This block is the request side of one DMA channel that works in single-address mode. It watches an active-low external request pin. When the channel is enabled and level sensing is selected, a low level seen on a rising clock edge is latched as a held request. The block then raises a bus request and waits for the external bus to become free. That event is signalled by a one-clock bus-break strobe.

When the break arrives, the held request is cleared and one single-address transfer cycle runs. It lasts a fixed number of clocks, and the active-low acknowledge is driven for that whole cycle. While a request is held and while the transfer runs, the pin is not looked at. Sampling resumes once the cycle is over. A release timer makes sure the bus stays with other masters for a minimum number of clocks between two consecutive DMA cycles.

The control bits (enable and level mode) are loaded through a one-cycle write strobe. The first pin sample is taken on the clock edge after the enabling write. Clearing the enable drops a request that is held but has not started. A transfer that is already running finishes normally.

Top module: `dma_req_front`

## Requirements
- R1: The level-mode bit must be 1 for the pin to be accepted. With it at 0 a low pin never raises `bus_req_o`.
- R2: The pin is ignored while the enable bit is 0. After a write that sets enable=1 and level=1, the pin is first sampled on the following rising edge, not on the edge of the write itself.
- R3: A low pin sampled while accepting raises `bus_req_o` in the next cycle. The request stays held, with `bus_req_o` at 1, whatever the pin does afterwards, until a transfer starts or the request is aborted.
- R4: A `bus_brk_i` strobe sampled while a request is held, and after the release time has elapsed, clears `bus_req_o` and starts the transfer in the next cycle. A strobe with no held request has no effect.
- R5: Each accepted request gives exactly one transfer cycle. In it, `xfer_o` is 1 and `ack_no` is 0 for exactly XFER_CYC consecutive clocks (default 2).
- R6: The pin is ignored from acceptance until the transfer ends. A low level sampled during the transfer is not held. Sampling resumes on the first edge after the transfer ends.
- R7: Between two transfer cycles, `xfer_o` is 0 for at least GAP_CYC clocks (default 2, never below 2). A break strobe inside that window is ignored, and the held request keeps waiting.
- R8: Clearing the enable bit drops a held request that has not started, and the block returns to idle. A transfer that has started completes in full.
- R9: While `rst_ni` is low, the block is idle, no request is held, `ack_no`=1, `xfer_o`=0, `bus_req_o`=0, and the control bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | External transfer request pin, active low |
| cfg_we_i | input | 1 | One-cycle write strobe for the control bits |
| cfg_en_i | input | 1 | Enable value loaded on write |
| cfg_lvl_i | input | 1 | Level-sense mode value loaded on write |
| bus_brk_i | input | 1 | One-clock strobe: external bus free for DMA |
| ack_no | output | 1 | Transfer acknowledge, active low |
| xfer_o | output | 1 | Transfer cycle in progress |
| bus_req_o | output | 1 | Request held, bus wanted |

## Verification
Two collisions matter most. The first is a control write that clears the enable landing on the same edge as the bus-break strobe that would start a held request. The second is a break strobe that arrives while the release window after the previous transfer is still open. The bench provokes the first by pulsing the write strobe and the break together. The registered enable is still set on that edge, so the transfer must start and then run to its end. The bench provokes the second by holding the pin low and the break high continuously. The shortest gap between transfers must then equal GAP_CYC exactly. Both cases are judged against a behavioural model that is compared every clock, and by explicit counts of transfer and gap lengths.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_XFER = 2'd2
  } dma_st_e;
endpackage

// File: rtl/dma_cfg_reg.sv
module dma_cfg_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic en_i,
  input  logic lvl_i,
  output logic en_o,
  output logic lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      lvl_o <= 1'b0;
    end else if (we_i) begin
      en_o  <= en_i;
      lvl_o <= lvl_i;
    end
  end
endmodule

// File: rtl/dma_down_cnt.sv
module dma_down_cnt #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_req_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    lvl_i,
  input  logic    req_ni,
  input  logic    brk_i,
  input  logic    x_zero_i,
  input  logic    gap_zero_i,
  output dma_st_e st_o,
  output logic    load_x_o,
  output logic    load_gap_o
);
  dma_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    load_x_o   = 1'b0;
    load_gap_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (en_i && lvl_i && !req_ni) st_d = ST_PEND;
      ST_PEND: begin
        if (!en_i) st_d = ST_IDLE;            // abort before start
        else if (brk_i && gap_zero_i) begin
          st_d     = ST_XFER;
          load_x_o = 1'b1;
        end
      end
      ST_XFER: if (x_zero_i) begin
        st_d       = ST_IDLE;
        load_gap_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
  import dma_req_pkg::*;
#(
  parameter int XFER_CYC = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic cfg_we_i,
  input  logic cfg_en_i,
  input  logic cfg_lvl_i,
  input  logic bus_brk_i,
  output logic ack_no,
  output logic xfer_o,
  output logic bus_req_o
);
  localparam int XW = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
  localparam int GW = (GAP_CYC  > 1) ? $clog2(GAP_CYC)  : 1;

  logic    en_q, lvl_q;
  logic    load_x, load_gap, x_zero, gap_zero;
  dma_st_e st;

  dma_cfg_reg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .en_i  (cfg_en_i),
    .lvl_i (cfg_lvl_i),
    .en_o  (en_q),
    .lvl_o (lvl_q)
  );

  dma_down_cnt #(.W(XW)) u_xcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_x),
    .val_i (XW'(XFER_CYC - 1)),
    .zero_o(x_zero)
  );

  dma_down_cnt #(.W(GW)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_gap),
    .val_i (GW'(GAP_CYC - 1)),
    .zero_o(gap_zero)
  );

  dma_req_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .lvl_i     (lvl_q),
    .req_ni    (req_ni),
    .brk_i     (bus_brk_i),
    .x_zero_i  (x_zero),
    .gap_zero_i(gap_zero),
    .st_o      (st),
    .load_x_o  (load_x),
    .load_gap_o(load_gap)
  );

  assign xfer_o    = (st == ST_XFER);
  assign ack_no    = ~xfer_o;
  assign bus_req_o = (st == ST_PEND);

  // run-length trackers for the checks below
  int run_q, gap_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 0;
      gap_run_q <= GAP_CYC;
    end else begin
      run_q     <= xfer_o ? run_q + 1 : 0;
      gap_run_q <= xfer_o ? 0 : ((gap_run_q >= GAP_CYC) ? gap_run_q : gap_run_q + 1);
    end
  end

  AST_REQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(!req_ni && en_q && lvl_q)); // R3
  AST_START_ON_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_o) |-> $past(bus_brk_i) && $past(bus_req_o)); // R4
  AST_XFER_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_o) |-> run_q == XFER_CYC); // R5
  AST_BUS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_o) |-> gap_run_q >= GAP_CYC); // R7
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !en_q) |=> !bus_req_o); // R8
endmodule

// File: tb/dma_req_front_tb_top.sv
module dma_req_front_tb_top;
  localparam int CLK_P = 10;
  localparam int XC    = 2;
  localparam int GC    = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_ni = 1'b1;
  logic cfg_we_i = 1'b0, cfg_en_i = 1'b0, cfg_lvl_i = 1'b0, bus_brk_i = 1'b0;
  logic ack_no, xfer_o, bus_req_o;

  int n_vec = 0, n_err = 0;
  string phase = "R9";

  dma_req_front #(.XFER_CYC(XC), .GAP_CYC(GC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_ni(req_ni), .cfg_we_i(cfg_we_i),
    .cfg_en_i(cfg_en_i), .cfg_lvl_i(cfg_lvl_i), .bus_brk_i(bus_brk_i),
    .ack_no(ack_no), .xfer_o(xfer_o), .bus_req_o(bus_req_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  // behavioural reference: 0 idle, 1 held, 2 transfer
  int m_st = 0, m_x = 0, m_gap = 0;
  bit m_en = 0, m_lvl = 0;
  always @(posedge clk_i) begin : ref_model
    int nst, nx, ng;
    if (!rst_ni) begin
      m_st = 0; m_x = 0; m_gap = 0; m_en = 0; m_lvl = 0;
    end else begin
      nst = m_st;
      nx  = (m_x > 0) ? m_x - 1 : 0;
      ng  = (m_gap > 0) ? m_gap - 1 : 0;
      if (m_st == 0) begin
        if (m_en && m_lvl && !req_ni) nst = 1;
      end else if (m_st == 1) begin
        if (!m_en) nst = 0;
        else if (bus_brk_i && m_gap == 0) begin nst = 2; nx = XC; end
      end else begin
        if (m_x <= 1) begin nst = 0; ng = GC - 1; end
      end
      if (cfg_we_i) begin m_en = cfg_en_i; m_lvl = cfg_lvl_i; end
      m_st = nst; m_x = nx; m_gap = ng;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    check({phase, " bus_req_o"}, bus_req_o, m_st == 1);
    check({phase, " xfer_o"},    xfer_o,    m_st == 2);
    check({phase, " ack_no"},    ack_no,    m_st != 2);
  endtask

  task automatic wr(bit en, bit lvl);
    cfg_we_i = 1; cfg_en_i = en; cfg_lvl_i = lvl;
    tick();
    cfg_we_i = 0;
  endtask

  initial begin : watchdog
    #(CLK_P * 20000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  int low_run, min_gap, n_xfer, xlen;
  bit prev_x;

  initial begin
    repeat (3) tick();
    check("R9 reset ack_no", ack_no, 1'b1);
    check("R9 reset xfer_o", xfer_o, 1'b0);
    @(negedge clk_i); rst_ni = 1;

    phase = "R2"; req_ni = 0;
    repeat (4) tick();
    check("R2 disabled pin ignored", bus_req_o, 1'b0);

    phase = "R1"; wr(1, 0);
    repeat (4) tick();
    check("R1 level bit clear", bus_req_o, 1'b0);

    phase = "R2"; wr(1, 1);
    check("R2 not sampled on write edge", bus_req_o, 1'b0);
    tick();
    check("R2 sampled next edge", bus_req_o, 1'b1);

    phase = "R3"; req_ni = 1;
    repeat (3) tick();
    check("R3 request held", bus_req_o, 1'b1);

    phase = "R4"; bus_brk_i = 1; tick(); bus_brk_i = 0;
    check("R4 transfer starts", xfer_o, 1'b1);
    check("R4 request cleared", bus_req_o, 1'b0);
    phase = "R5"; tick();
    check("R5 ack second cycle", ack_no, 1'b0);
    tick();
    check("R5 transfer ended", xfer_o, 1'b0);

    phase = "R4"; repeat (3) tick();
    bus_brk_i = 1; tick(); bus_brk_i = 0;
    check("R4 break without request", xfer_o, 1'b0);

    phase = "R6"; req_ni = 0; tick(); req_ni = 1;
    bus_brk_i = 1; tick(); bus_brk_i = 0;
    req_ni = 0; tick(); req_ni = 1; tick();
    check("R6 pin ignored during transfer", bus_req_o, 1'b0);
    tick();
    check("R6 still idle", bus_req_o, 1'b0);
    req_ni = 0; tick();
    check("R6 sampling resumed", bus_req_o, 1'b1);

    phase = "R7"; bus_brk_i = 1;
    low_run = 0; min_gap = 1000; n_xfer = 0; prev_x = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (xfer_o && !prev_x) begin
        n_xfer++;
        if (n_xfer > 1 && low_run < min_gap) min_gap = low_run;
      end
      low_run = xfer_o ? 0 : low_run + 1;
      prev_x = xfer_o;
    end
    bus_brk_i = 0; req_ni = 1;
    check("R7 several transfers", n_xfer > 3, 1'b1);
    check("R7 minimum release gap", min_gap == GC, 1'b1);
    xlen = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (xfer_o) xlen++;
    end
    check("R5 final transfer length", xlen <= XC, 1'b1);

    phase = "R8"; req_ni = 0; tick(); req_ni = 1;
    check("R8 held before abort", bus_req_o, 1'b1);
    wr(0, 1); tick();
    check("R8 abort clears request", bus_req_o, 1'b0);
    repeat (2) tick();
    check("R8 stays idle", xfer_o, 1'b0);

    wr(1, 1); req_ni = 0; tick(); req_ni = 1;
    cfg_we_i = 1; cfg_en_i = 0; cfg_lvl_i = 1; bus_brk_i = 1;
    tick();
    cfg_we_i = 0; bus_brk_i = 0;
    check("R8 break wins on disabling edge", xfer_o, 1'b1);
    tick();
    check("R8 transfer completes", ack_no, 1'b0);
    repeat (3) tick();
    check("R8 idle after completion", xfer_o | bus_req_o, 1'b0);

    phase = "R9"; rst_ni = 0; tick();
    check("R9 reset clears", bus_req_o, 1'b0);
    rst_ni = 1; req_ni = 0; repeat (2) tick();
    check("R9 enable cleared by reset", bus_req_o, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule